// File: doc/BRIEF.md
# Serial Flash Page Program Sequencer

This block is the program engine inside a synthesizable model of a serial flash slave. A shift-register front end hands it whole bytes, a pulse when chip select goes low, and a pulse when chip select returns high. With the release pulse it also gives the count of clocks left over after the last whole byte. The sequencer collects an opcode, a three-byte address and the data bytes into a one-page staging buffer. When chip select is released it decides whether the command is valid.

A valid command starts a timed internal program cycle. During that cycle the staged bytes are merged into a small on-chip array with a bitwise AND, so a bit can only go from 1 to 0. A busy flag stays high for the whole cycle. A one-cycle pulse at the end tells the owner of the write-enable latch to clear it. A registered read port lets the surrounding model, or a bench, see the array contents.

Top module: `page_prog_seq`

## Requirements
- R1: After reset, busy and wel_clr are 0 and every array location reads FFh.
- R2: A command is byte 0 = opcode, then three address bytes, high byte first, then the data bytes. The high address byte is ignored. The middle byte's low bits select the page and the low byte gives the starting offset. Data byte k goes to offset (start + k) within that page.
- R3: A programmed location ends up holding the old value ANDed with the new byte, so no bit ever changes from 0 to 1.
- R4: Offsets wrap modulo 256 inside the page. When more than 256 data bytes are sent, only the last 256 are kept, each at its wrapped offset.
- R5: If wel is 0 during the release pulse, the command is discarded and no cycle starts.
- R6: If tail_bits is nonzero during the release pulse (the clock count is not a multiple of eight), the command is discarded.
- R7: After an accepted release, busy is 1 from the next cycle for exactly TPP_CYC cycles.
- R8: wel_clr is high for exactly one cycle: the first cycle in which busy is low again.
- R9: A frame that starts, or carries bytes, while busy is 1 has no effect on the array. The cycle in progress still writes its own data correctly.
- R10: Only opcode 02h is accepted. Any other opcode is discarded.
- R11: prot_lvl = L protects the L highest-numbered pages (L of NUM_PAGES or more protects all). A command to a protected page is discarded, and a command to an unprotected page is accepted.
- R12: A frame with fewer than one data byte after the address is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_start | input | 1 | Pulse: chip select went low |
| byte_vld | input | 1 | Pulse: byte_val holds a received byte |
| byte_val | input | 8 | Received byte |
| sel_end | input | 1 | Pulse: chip select went high |
| tail_bits | input | 3 | Clocks beyond the last whole byte, valid with sel_end |
| wel | input | 1 | Write-enable latch state |
| prot_lvl | input | $clog2(NUM_PAGES+1) | Number of protected top pages |
| rd_addr | input | 8+$clog2(NUM_PAGES) | Array read address |
| rd_data | output | 8 | Array byte, one cycle after rd_addr |
| busy | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | Pulse: clear the write-enable latch |

## Verification
Frames are sent in several shapes. A short burst into fresh cells shows plain placement. A second burst that overlaps the first shows the AND merge, as opposed to an overwrite. A burst that starts near the end of a page shows the wrap, as opposed to spilling into the next page. A 300-byte burst shows that only the last 256 bytes are kept. Frames that differ from a valid one in exactly one respect (latch, leftover clocks, opcode, protection level, missing data, arriving while busy) show that each gate rejects on its own. For every frame the bench also measures the busy length and the clear pulse.

// File: rtl/fps_pkg.sv
// Shared constants and types for the page program sequencer.
// Assumes byte-wide framing and 256-byte pages.
package fps_pkg;
    localparam int PAGE_BYTES = 256;
    localparam logic [7:0] OP_PAGE_PROG = 8'h02;

    // Position within a received frame
    typedef enum logic [2:0] {
        PH_OP,
        PH_AHI,
        PH_AMID,
        PH_ALO,
        PH_DATA
    } phase_t;
endpackage

// File: rtl/fps_frame.sv
// Frame capture and page staging buffer.
// Decodes the opcode and address bytes, stores data bytes at wrapped page
// offsets (a later byte replaces an earlier one), and at chip-select release
// judges whether the command may run. Assumes sel_start, byte_vld and sel_end
// never pulse in the same cycle. The buffer is left alone while busy.
module fps_frame
    import fps_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int PG_W      = 2,
    parameter int PROT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              byte_vld,
    input  logic [7:0]        byte_val,
    input  logic              sel_end,
    input  logic [2:0]        tail_bits,
    input  logic              wel,
    input  logic [PROT_W-1:0] prot_lvl,
    input  logic              busy,
    input  logic [7:0]        buf_idx,
    output logic              go,
    output logic [PG_W-1:0]   go_page,
    output logic [7:0]        buf_byte,
    output logic              buf_vld
);
    phase_t                ph;
    logic [7:0]            opc;
    logic [PG_W-1:0]       page;
    logic [7:0]            off;
    logic                  got_data;
    logic                  dead;
    logic [PAGE_BYTES-1:0] vld;
    logic [7:0]            stage [PAGE_BYTES];
    logic                  take;
    logic                  prot_hit;

    assign take = byte_vld && !busy && !dead;

    // Track frame phase, header fields, the write offset and the valid map
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_OP;
            opc      <= '0;
            page     <= '0;
            off      <= '0;
            got_data <= 1'b0;
            dead     <= 1'b0;
            vld      <= '0;
        end else if (sel_start) begin
            ph       <= PH_OP;
            got_data <= 1'b0;
            if (busy) begin
                dead <= 1'b1;
            end else begin
                dead <= 1'b0;
                vld  <= '0;
            end
        end else if (byte_vld && busy) begin
            dead <= 1'b1;
        end else if (take) begin
            case (ph)
                PH_OP:   begin opc  <= byte_val;             ph <= PH_AHI;  end
                PH_AHI:  begin                               ph <= PH_AMID; end
                PH_AMID: begin page <= byte_val[PG_W-1:0];   ph <= PH_ALO;  end
                PH_ALO:  begin off  <= byte_val;             ph <= PH_DATA; end
                default: begin
                    vld[off] <= 1'b1;
                    off      <= off + 8'd1;
                    got_data <= 1'b1;
                end
            endcase
        end
    end

    // Store data bytes at their wrapped offset
    always_ff @(posedge clk) begin
        if (take && !sel_start && ph == PH_DATA)
            stage[off] <= byte_val;
    end

    // The highest prot_lvl pages are protected
    assign prot_hit = (int'(page) + int'(prot_lvl)) >= NUM_PAGES;

    // Accept at release only when every condition holds
    assign go = sel_end && !busy && !dead && wel && (tail_bits == 3'd0)
             && (opc == OP_PAGE_PROG) && (ph == PH_DATA) && got_data && !prot_hit;

    assign go_page  = page;
    assign buf_byte = stage[buf_idx];
    assign buf_vld  = vld[buf_idx];

    // R4
    fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !sel_start && ph == PH_DATA)
            |=> (vld[$past(off)] && off == $past(off) + 8'd1));

    // R12
    data_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (vld != '0));
endmodule

// File: rtl/fps_engine.sv
// Program-cycle timer and byte array.
// On go, holds busy for TPP_CYC cycles. During the first 256 of them it walks
// the staging buffer and ANDs each valid byte into the chosen page. It pulses
// wel_clr once when the cycle ends. Assumes TPP_CYC >= 256. The array resets
// to the erased value FFh and has a registered read port.
module fps_engine
    import fps_pkg::*;
#(
    parameter int NUM_PAGES = 4,
    parameter int TPP_CYC   = 300,
    parameter int PG_W      = 2,
    parameter int ADDR_W    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [PG_W-1:0]   go_page,
    input  logic [7:0]        buf_byte,
    input  logic              buf_vld,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        buf_idx,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              wel_clr
);
    localparam int CNT_W     = $clog2(TPP_CYC + 1);
    localparam int MEM_BYTES = NUM_PAGES * PAGE_BYTES;

    logic [CNT_W-1:0]  cnt;
    logic [PG_W-1:0]   page_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        mem [MEM_BYTES];
    logic [31:0]       run_len;

    // Run the cycle timer and raise the end-of-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            wel_clr <= 1'b0;
            cnt     <= '0;
            page_q  <= '0;
        end else begin
            wel_clr <= 1'b0;
            if (go && !busy) begin
                busy   <= 1'b1;
                cnt    <= '0;
                page_q <= go_page;
            end else if (busy) begin
                if (cnt == CNT_W'(TPP_CYC - 1)) begin
                    busy    <= 1'b0;
                    wel_clr <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign buf_idx = cnt[7:0];
    assign wr_en   = busy && (int'(cnt) < PAGE_BYTES) && buf_vld;
    assign wr_addr = {page_q, buf_idx};

    // Merge staged bytes one-way into the array and serve reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
            rd_data <= 8'hFF;
        end else begin
            if (wr_en) mem[wr_addr] <= mem[wr_addr] & buf_byte;
            rd_data <= mem[rd_addr];
        end
    end

    // Independent busy run-length counter for checking
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= '0;
        else                 run_len <= run_len + 32'd1;
    end

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_len) == 32'(TPP_CYC - 1)));

    // R8
    clr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wel_clr);

    // R8
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

    // R9
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
endmodule

// File: rtl/page_prog_seq.sv
// Top of the page program sequencer: frame capture feeding the timed
// program engine. Assumes NUM_PAGES >= 2 and TPP_CYC >= 256.
module page_prog_seq #(
    parameter int NUM_PAGES = 4,
    parameter int TPP_CYC   = 300,
    localparam int PG_W     = $clog2(NUM_PAGES),
    localparam int ADDR_W   = 8 + PG_W,
    localparam int PROT_W   = $clog2(NUM_PAGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_start,
    input  logic              byte_vld,
    input  logic [7:0]        byte_val,
    input  logic              sel_end,
    input  logic [2:0]        tail_bits,
    input  logic              wel,
    input  logic [PROT_W-1:0] prot_lvl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              wel_clr
);
    logic            go;
    logic [PG_W-1:0] go_page;
    logic [7:0]      buf_idx;
    logic [7:0]      buf_byte;
    logic            buf_vld;

    fps_frame #(.NUM_PAGES(NUM_PAGES), .PG_W(PG_W), .PROT_W(PROT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .byte_vld(byte_vld),
        .byte_val(byte_val), .sel_end(sel_end), .tail_bits(tail_bits),
        .wel(wel), .prot_lvl(prot_lvl), .busy(busy), .buf_idx(buf_idx),
        .go(go), .go_page(go_page), .buf_byte(buf_byte), .buf_vld(buf_vld)
    );

    fps_engine #(.NUM_PAGES(NUM_PAGES), .TPP_CYC(TPP_CYC), .PG_W(PG_W), .ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .go_page(go_page),
        .buf_byte(buf_byte), .buf_vld(buf_vld), .rd_addr(rd_addr),
        .buf_idx(buf_idx), .rd_data(rd_data), .busy(busy), .wel_clr(wel_clr)
    );
endmodule

// File: tb/page_prog_seq_test.sv
module page_prog_seq_test;
    localparam int TPP = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_start = 1'b0, byte_vld = 1'b0, sel_end = 1'b0, wel = 1'b0;
    logic [7:0] byte_val = '0;
    logic [2:0] tail_bits = '0;
    logic [2:0] prot_lvl = '0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, wel_clr;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_mem [1024];

    always #2 clk = ~clk;

    page_prog_seq #(.NUM_PAGES(4), .TPP_CYC(TPP)) uut (
        .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .byte_vld(byte_vld),
        .byte_val(byte_val), .sel_end(sel_end), .tail_bits(tail_bits),
        .wel(wel), .prot_lvl(prot_lvl), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .wel_clr(wel_clr)
    );

    typedef struct packed {
        logic        w;
        logic [2:0]  tail;
        logic [7:0]  op;
        logic [23:0] addr;
        logic [9:0]  nb;
        logic [7:0]  seed;
        logic [2:0]  prot;
        logic        acc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 3'd0, 8'h02, 24'h000010, 10'd20,  8'h3C, 3'd0, 1'b1},  // R2 fresh
        '{1'b1, 3'd0, 8'h02, 24'h000014, 10'd20,  8'hA5, 3'd0, 1'b1},  // R3 overlap
        '{1'b1, 3'd0, 8'h02, 24'h0001F0, 10'd40,  8'h11, 3'd0, 1'b1},  // R4 wrap
        '{1'b1, 3'd0, 8'h02, 24'h000205, 10'd300, 8'h77, 3'd0, 1'b1},  // R4 overlong
        '{1'b0, 3'd0, 8'h02, 24'h000300, 10'd16,  8'h01, 3'd0, 1'b0},  // R5
        '{1'b1, 3'd3, 8'h02, 24'h000300, 10'd16,  8'h02, 3'd0, 1'b0},  // R6
        '{1'b1, 3'd0, 8'h03, 24'h000300, 10'd16,  8'h03, 3'd0, 1'b0},  // R10
        '{1'b1, 3'd0, 8'h02, 24'h000300, 10'd16,  8'h04, 3'd1, 1'b0},  // R11 protected
        '{1'b1, 3'd0, 8'h02, 24'hAB0280, 10'd8,   8'h5A, 3'd1, 1'b1},  // R11 open, R2 high byte
        '{1'b1, 3'd0, 8'h02, 24'h000300, 10'd0,   8'h05, 3'd0, 1'b0}   // R12
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R2";  1: return "R3";  2: return "R4";  3: return "R4";
            4: return "R5";  5: return "R6";  6: return "R10"; 7: return "R11";
            8: return "R11"; default: return "R12";
        endcase
    endfunction

    function automatic logic [7:0] pat(logic [7:0] seed, int k);
        return 8'((int'(seed) + k * 29) ^ (k >> 2));
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic put_byte(logic [7:0] b);
        byte_vld = 1'b1;
        byte_val = b;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    // Drive one frame; returns at the negedge after the release pulse
    task automatic send_frame(vec_t v);
        wel      = v.w;
        prot_lvl = v.prot;
        sel_start = 1'b1;
        @(negedge clk);
        sel_start = 1'b0;
        put_byte(v.op);
        put_byte(v.addr[23:16]);
        put_byte(v.addr[15:8]);
        put_byte(v.addr[7:0]);
        for (int k = 0; k < int'(v.nb); k++) put_byte(pat(v.seed, k));
        sel_end   = 1'b1;
        tail_bits = v.tail;
        @(negedge clk);
        sel_end   = 1'b0;
        tail_bits = '0;
    endtask

    task automatic model(vec_t v);
        logic [7:0] sb [256];
        bit         sv [256];
        int         base;
        for (int p = 0; p < 256; p++) sv[p] = 1'b0;
        for (int k = 0; k < int'(v.nb); k++) begin
            sb[(int'(v.addr[7:0]) + k) % 256] = pat(v.seed, k);
            sv[(int'(v.addr[7:0]) + k) % 256] = 1'b1;
        end
        base = int'(v.addr[9:8]) * 256;
        for (int p = 0; p < 256; p++)
            if (sv[p]) exp_mem[base + p] = exp_mem[base + p] & sb[p];
    endtask

    task automatic rd(int a, output logic [7:0] d);
        rd_addr = 10'(a);
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic cmp_page(int pg, string tag);
        logic [7:0] d;
        int bad = 0, fa = 0, fe = 0;
        for (int p = 0; p < 256; p++) begin
            rd(pg * 256 + p, d);
            if (d !== exp_mem[pg * 256 + p]) begin
                if (bad == 0) begin fa = int'(d); fe = int'(exp_mem[pg * 256 + p]); end
                bad++;
            end
        end
        check(bad == 0, tag, fa, fe);
    endtask

    // Measure busy length and the clear pulse; called at the negedge after release
    task automatic time_cycle(string tag);
        int n = 0;
        while (busy && n < 2 * TPP) begin
            n++;
            @(negedge clk);
        end
        check(n == TPP, {tag, "/R7 busy length"}, n, TPP);
        check(wel_clr === 1'b1, {tag, "/R8 clear pulse"}, int'(wel_clr), 1);
        @(negedge clk);
        check(wel_clr === 1'b0, {tag, "/R8 pulse width"}, int'(wel_clr), 0);
    endtask

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        logic [7:0] d;
        vec_t va, vb;
        for (int i = 0; i < 1024; i++) exp_mem[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        check(wel_clr === 1'b0, "R1 wel_clr", int'(wel_clr), 0);
        rd(0, d);     check(d === 8'hFF, "R1 mem[0]", int'(d), 8'hFF);
        rd(10'h155, d); check(d === 8'hFF, "R1 mem[155]", int'(d), 8'hFF);
        rd(10'h3FF, d); check(d === 8'hFF, "R1 mem[3FF]", int'(d), 8'hFF);

        // Table of frames
        for (int i = 0; i < NV; i++) begin
            send_frame(VECS[i]);
            check(busy === VECS[i].acc, {vec_tag(i), " accept"}, int'(busy), int'(VECS[i].acc));
            if (VECS[i].acc) begin
                time_cycle(vec_tag(i));
                model(VECS[i]);
            end else begin
                repeat (3) @(negedge clk);
                check(busy === 1'b0, {vec_tag(i), " stays idle"}, int'(busy), 0);
            end
            cmp_page(int'(VECS[i].addr[9:8]), {vec_tag(i), " page contents"});
        end

        // R9: a second frame sent while busy changes nothing
        va = '{1'b1, 3'd0, 8'h02, 24'h000080, 10'd10, 8'h99, 3'd0, 1'b1};
        vb = '{1'b1, 3'd0, 8'h02, 24'h000340, 10'd6,  8'h00, 3'd0, 1'b0};
        send_frame(va);
        check(busy === 1'b1, "R9 first accepted", int'(busy), 1);
        send_frame(vb);
        check(busy === 1'b1, "R9 still busy", int'(busy), 1);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R9 no second cycle", int'(busy), 0);
        model(va);
        cmp_page(0, "R9 running cycle intact");
        cmp_page(3, "R9 busy frame ignored");

        summary();
    end
endmodule